// File: doc/BRIEF.md
# Flash Program Image Loader

This block copies one fixed-size program image from a serial NOR flash into the program memory of a small processor. It receives the image's 32-bit flash start address and a one-cycle start pulse. It then asserts the processor's reset and selects the flash. It sends one read command followed by the address, and streams the image bytes from the device. Each byte goes out on a single-beat memory write port.

The destination address begins at page 2. It climbs through the address space, leaving out the zero page (page 0), the stack page (page 1) and one parameterised 256-byte I/O page. With 16 address bits the image is therefore 65,536 − 768 = 64,768 bytes long. The memory port has a ready input. While a write is waiting, the serial clock stays parked low, so the flash is never clocked past a byte that has not yet been stored. The flash is only ever read.

The controller is a five-state machine:
- `ST_IDLE`: waits for `start`.
- `ST_HEADER`: shifts out the command byte and the address bytes.
- `ST_DATA`: clocks in one image byte.
- `ST_STORE`: presents the byte on the memory port until it is accepted.
- `ST_FINISH`: releases the processor and pulses `done`.

Its transitions are:
- IDLE→HEADER on start.
- HEADER→DATA after the last address byte.
- DATA→STORE when a byte is complete.
- STORE→DATA when a byte that is not the last one is accepted.
- STORE→FINISH when the last byte is accepted.
- FINISH→IDLE unconditionally.

Top module: `flash_image_loader`

## Requirements
- R1: One load performs exactly 2^ADDR_W − 768 memory writes, and none after that.
- R2: Destination addresses start at 0x0200 and rise by one. Any address on the I/O page (address bits above bit 7 equal to IO_PAGE) is replaced by the first address of the following page. Pages 0 and 1 are never written.
- R3: With WIDE_ADDR = 0, the device sees command byte 0x03 and then three address bytes, most significant first, carrying start_addr[23:0]. start_addr[31:24] is dropped.
- R4: With WIDE_ADDR = 1, the device sees command byte 0x13 and then four address bytes, most significant first, carrying all of start_addr.
- R5: The serial link is mode 0, most significant bit first. spi_sck rests low, spi_mosi changes while spi_sck is low, and spi_miso is sampled on each rising spi_sck. The n-th byte written is the flash byte at start address + n.
- R6: spi_cs_n is high at rest. It falls once per load, one cycle after start, and stays low until the last byte has been received. It is high whenever done is high. spi_sck is low whenever spi_cs_n is high.
- R7: cpu_reset rises in the cycle after start. It stays high during every memory write and falls in the same cycle that done rises.
- R8: done is a single-cycle pulse. It comes one cycle after the last write is accepted.
- R9: While mem_we is high and mem_ready is low, mem_we, mem_addr and mem_wdata hold their values and spi_sck stays low. No byte is lost or repeated.
- R10: A start pulse during a load is ignored. The load in progress continues unchanged and no second read is issued.
- R11: After reset, spi_cs_n = 1, spi_sck = 0, mem_we = 0, cpu_reset = 0 and done = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to load an image |
| start_addr | input | 32 | Flash byte address of the image's first byte |
| spi_sck | output | 1 | Serial clock to the flash |
| spi_cs_n | output | 1 | Active-low flash select |
| spi_mosi | output | 1 | Command and address bits to the flash |
| spi_miso | input | 1 | Data bits from the flash |
| mem_we | output | 1 | Write request to program memory |
| mem_addr | output | ADDR_W (16) | Destination byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_ready | input | 1 | Memory accepts the write in this cycle |
| cpu_reset | output | 1 | Holds the processor in reset during the copy |
| done | output | 1 | One-cycle pulse when the image is in place |

## Verification
A wrong address-stepper state shows at the ports within one write. The next accepted mem_addr is out of sequence, or it lands on page 0, page 1 or the I/O page. An off-by-one in the byte counter shows only at the end: done arrives one write early, or one write beyond the expected image appears. A bit-counter or phase error in the serial engine shifts every later byte one bit or one byte against the flash contents, so it is caught at the first written byte. A stall that does not park the clock loses the next byte, and the mismatch appears at the write that follows the stall.

// File: rtl/fil_pkg.sv
package fil_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEADER,
        ST_DATA,
        ST_STORE,
        ST_FINISH
    } fil_state_e;

    localparam logic [7:0] CMD_READ_3B = 8'h03;
    localparam logic [7:0] CMD_READ_4B = 8'h13;

endpackage

// File: rtl/fil_spi_byte.sv
module fil_spi_byte #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       byte_done,
    output logic [7:0] rx_byte
);

    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    logic             busy;
    logic [DIV_W-1:0] div_q;
    logic [2:0]       bit_q;
    logic [7:0]       tx_q;
    logic [7:0]       rx_q;
    logic             tick;

    assign tick    = busy && (div_q == DIV_LAST);
    assign mosi    = tx_q[7];
    assign rx_byte = rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            sck       <= 1'b0;
            byte_done <= 1'b0;
            div_q     <= '0;
            bit_q     <= '0;
            tx_q      <= '0;
            rx_q      <= '0;
        end else begin
            byte_done <= 1'b0;
            if (go && !busy) begin
                busy  <= 1'b1;
                sck   <= 1'b0;
                div_q <= '0;
                bit_q <= '0;
                tx_q  <= tx_byte;
            end else if (busy) begin
                if (tick) begin
                    div_q <= '0;
                    if (!sck) begin
                        sck  <= 1'b1;
                        rx_q <= {rx_q[6:0], miso};
                    end else begin
                        sck <= 1'b0;
                        if (bit_q == 3'd7) begin
                            busy      <= 1'b0;
                            byte_done <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 3'd1;
                            tx_q  <= {tx_q[6:0], 1'b0};
                        end
                    end
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
        end
    end

    AST_SCK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck); // R5
    AST_GO_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy); // R5

endmodule

// File: rtl/fil_dest_step.sv
module fil_dest_step #(
    parameter int ADDR_W  = 16,
    parameter int IO_PAGE = 'hD0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);

    localparam int PAGE_W      = ADDR_W - 8;
    localparam int IMAGE_BYTES = (1 << ADDR_W) - 3 * 256;
    localparam int CNT_W       = $clog2(IMAGE_BYTES);
    localparam logic [PAGE_W-1:0] IO_PG    = PAGE_W'(IO_PAGE);
    localparam logic [PAGE_W-1:0] FIRST_PG = PAGE_W'(2);
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(IMAGE_BYTES - 1);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;

    function automatic logic [ADDR_W-1:0] hop_io(input logic [ADDR_W-1:0] a);
        if (a[ADDR_W-1:8] == IO_PG) begin
            return {IO_PG + PAGE_W'(1), 8'h00};
        end
        return a;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else if (clear) begin
            addr_q <= hop_io({FIRST_PG, 8'h00});
            cnt_q  <= '0;
        end else if (step) begin
            addr_q <= hop_io(addr_q + 1'b1);
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign addr = addr_q;
    assign last = (cnt_q == CNT_LAST);

    AST_DEST_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (addr[ADDR_W-1:8] >= FIRST_PG) && (addr[ADDR_W-1:8] != IO_PG)); // R2
    AST_DEST_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> addr > $past(addr)); // R2
    AST_NO_STEP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> !step); // R1

endmodule

// File: rtl/flash_image_loader.sv
module flash_image_loader
    import fil_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int IO_PAGE   = 'hD0,
    parameter int WIDE_ADDR = 0,
    parameter int HALF_DIV  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       start_addr,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ready,
    output logic              cpu_reset,
    output logic              done
);

    localparam int HDR_LEN = (WIDE_ADDR != 0) ? 5 : 4;
    localparam logic [7:0] READ_CMD = (WIDE_ADDR != 0) ? CMD_READ_4B : CMD_READ_3B;
    localparam logic [2:0] HDR_LAST = 3'(HDR_LEN - 1);

    fil_state_e  state_q, state_d;
    logic [31:0] base_q;
    logic [2:0]  hdr_q;
    logic        spi_go, spi_done;
    logic [7:0]  spi_tx, spi_rx;
    logic        dst_clear, dst_step, dst_last;

    function automatic logic [7:0] hdr_byte(input logic [2:0] idx, input logic [31:0] a);
        int sh;
        if (idx == 3'd0) begin
            return READ_CMD;
        end
        sh = 8 * (HDR_LEN - 1 - int'(idx));
        return 8'(a >> sh);
    endfunction

    fil_spi_byte #(.HALF_DIV(HALF_DIV)) u_spi (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (spi_go),
        .tx_byte   (spi_tx),
        .miso      (spi_miso),
        .sck       (spi_sck),
        .mosi      (spi_mosi),
        .byte_done (spi_done),
        .rx_byte   (spi_rx)
    );

    fil_dest_step #(.ADDR_W(ADDR_W), .IO_PAGE(IO_PAGE)) u_dest (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (dst_clear),
        .step  (dst_step),
        .addr  (mem_addr),
        .last  (dst_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        spi_go    = 1'b0;
        spi_tx    = 8'h00;
        dst_clear = 1'b0;
        dst_step  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d   = ST_HEADER;
                    spi_go    = 1'b1;
                    spi_tx    = READ_CMD;
                    dst_clear = 1'b1;
                end
            end
            ST_HEADER: begin
                if (spi_done) begin
                    spi_go = 1'b1;
                    if (hdr_q == HDR_LAST) begin
                        state_d = ST_DATA;
                    end else begin
                        spi_tx = hdr_byte(hdr_q + 3'd1, base_q);
                    end
                end
            end
            ST_DATA: begin
                if (spi_done) begin
                    state_d = ST_STORE;
                end
            end
            ST_STORE: begin
                if (mem_ready) begin
                    if (dst_last) begin
                        state_d = ST_FINISH;
                    end else begin
                        dst_step = 1'b1;
                        spi_go   = 1'b1;
                        state_d  = ST_DATA;
                    end
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spi_cs_n  <= 1'b1;
            cpu_reset <= 1'b0;
            done      <= 1'b0;
            mem_we    <= 1'b0;
            mem_wdata <= '0;
            base_q    <= '0;
            hdr_q     <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        base_q    <= start_addr;
                        hdr_q     <= '0;
                        spi_cs_n  <= 1'b0;
                        cpu_reset <= 1'b1;
                    end
                end
                ST_HEADER: begin
                    if (spi_done) begin
                        hdr_q <= hdr_q + 3'd1;
                    end
                end
                ST_DATA: begin
                    if (spi_done) begin
                        mem_wdata <= spi_rx;
                        mem_we    <= 1'b1;
                    end
                end
                ST_STORE: begin
                    if (mem_ready) begin
                        mem_we <= 1'b0;
                        if (dst_last) begin
                            spi_cs_n <= 1'b1;
                        end
                    end
                end
                ST_FINISH: begin
                    cpu_reset <= 1'b0;
                    done      <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && !mem_ready |=> mem_we && $stable(mem_addr) && $stable(mem_wdata)); // R9
    AST_STALL_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !spi_sck); // R9
    AST_HELD_DURING_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> cpu_reset && !spi_cs_n); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cpu_reset && spi_cs_n); // R6
    AST_SCK_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck); // R6

endmodule

// File: tb/tb_flash_image_loader.sv
module tb_flash_rom #(
    parameter int ADDR_BYTES = 3
) (
    input  logic        sck,
    input  logic        cs_n,
    input  logic        mosi,
    output logic        miso,
    output logic [7:0]  cmd_seen,
    output logic [31:0] addr_seen,
    output int          sessions
);
    localparam int HDR_BITS = 8 * (ADDR_BYTES + 1);

    int          bitcnt = 0;
    logic [39:0] hdr_sh = '0;

    function automatic logic [7:0] rom_byte(input logic [31:0] a);
        return a[7:0] ^ {a[12:8], a[15:13]} ^ a[23:16] ^ a[31:24] ^ 8'h3C;
    endfunction

    initial begin
        miso = 1'b0; cmd_seen = '0; addr_seen = '0; sessions = 0;
    end

    always @(negedge cs_n) sessions = sessions + 1;

    always @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            bitcnt = 0;
        end else begin
            hdr_sh = {hdr_sh[38:0], mosi};
            bitcnt = bitcnt + 1;
            if (bitcnt == 8) cmd_seen = hdr_sh[7:0];
            if (bitcnt == HDR_BITS) addr_seen = (ADDR_BYTES == 4) ? hdr_sh[31:0] : {8'h00, hdr_sh[23:0]};
        end
    end

    always @(negedge sck) begin
        if (!cs_n && bitcnt >= HDR_BITS) begin
            int k;
            logic [7:0] d;
            k = bitcnt - HDR_BITS;
            d = rom_byte(addr_seen + 32'(k / 8));
            miso = d[7 - (k % 8)];
        end
    end
endmodule

module tb_flash_image_loader;
    localparam int AW = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    bit stall_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    logic a_start = 1'b0, a_sck, a_cs, a_mosi, a_miso, a_we, a_ready = 1'b1, a_cpu, a_done;
    logic [31:0] a_saddr = '0;
    logic [AW-1:0] a_addr;
    logic [7:0] a_wdata, a_cmd;
    logic [31:0] a_aseen;
    int a_sess;

    logic w_start = 1'b0, w_sck, w_cs, w_mosi, w_miso, w_we, w_ready = 1'b1, w_cpu, w_done;
    logic [31:0] w_saddr = '0;
    logic [AW-1:0] w_addr;
    logic [7:0] w_wdata, w_cmd;
    logic [31:0] w_aseen;
    int w_sess;

    logic [23:0] exp_a[$];
    logic [23:0] exp_w[$];
    logic [AW-1:0] w_last_addr = '0;

    flash_image_loader #(.ADDR_W(AW), .IO_PAGE(5), .WIDE_ADDR(0), .HALF_DIV(1)) dut (
        .clk(clk), .rst_n(rst_n), .start(a_start), .start_addr(a_saddr),
        .spi_sck(a_sck), .spi_cs_n(a_cs), .spi_mosi(a_mosi), .spi_miso(a_miso),
        .mem_we(a_we), .mem_addr(a_addr), .mem_wdata(a_wdata), .mem_ready(a_ready),
        .cpu_reset(a_cpu), .done(a_done));

    flash_image_loader #(.ADDR_W(AW), .IO_PAGE(7), .WIDE_ADDR(1), .HALF_DIV(1)) dut_wide (
        .clk(clk), .rst_n(rst_n), .start(w_start), .start_addr(w_saddr),
        .spi_sck(w_sck), .spi_cs_n(w_cs), .spi_mosi(w_mosi), .spi_miso(w_miso),
        .mem_we(w_we), .mem_addr(w_addr), .mem_wdata(w_wdata), .mem_ready(w_ready),
        .cpu_reset(w_cpu), .done(w_done));

    tb_flash_rom #(.ADDR_BYTES(3)) rom_a (.sck(a_sck), .cs_n(a_cs), .mosi(a_mosi), .miso(a_miso),
        .cmd_seen(a_cmd), .addr_seen(a_aseen), .sessions(a_sess));
    tb_flash_rom #(.ADDR_BYTES(4)) rom_w (.sck(w_sck), .cs_n(w_cs), .mosi(w_mosi), .miso(w_miso),
        .cmd_seen(w_cmd), .addr_seen(w_aseen), .sessions(w_sess));

    function automatic logic [7:0] flash_byte(input logic [31:0] a);
        return a[7:0] ^ {a[12:8], a[15:13]} ^ a[23:16] ^ a[31:24] ^ 8'h3C;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: push the expected (address, byte) stream of one load.
    task automatic push_image(input bit wide, input int io_page, input logic [31:0] base);
        logic [31:0] eff;
        int n;
        eff = wide ? base : (base & 32'h00FF_FFFF);
        n = 0;
        for (int a = 0; a < (1 << AW); a++) begin
            if ((a >> 8) >= 2 && (a >> 8) != io_page) begin
                if (wide) exp_w.push_back({16'(a), flash_byte(eff + 32'(n))});
                else      exp_a.push_back({16'(a), flash_byte(eff + 32'(n))});
                n++;
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #1;
            a_ready = stall_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end
    end

    // Monitor for the default-width instance
    initial begin
        logic stalled = 1'b0;
        logic [23:0] held = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (a_we && stalled)
                    check({16'(a_addr), a_wdata} == held, "R9", "write held through stall", {16'(a_addr), a_wdata}, held);
                if (a_we && !a_ready)
                    check(a_sck == 1'b0, "R9", "sck parked during stall", a_sck, 0);
                if (a_we && a_ready) begin
                    check(a_cpu == 1'b1, "R7", "cpu_reset during write", a_cpu, 1);
                    if (exp_a.size() == 0) begin
                        check(1'b0, "R1", "write beyond image", a_addr, 0);
                    end else begin
                        logic [23:0] it;
                        it = exp_a.pop_front();
                        check(16'(a_addr) == it[23:8], "R2", "destination address", a_addr, it[23:8]);
                        check(a_wdata == it[7:0], "R5", "written byte", a_wdata, it[7:0]);
                    end
                end
                stalled = a_we && !a_ready;
                held = {16'(a_addr), a_wdata};
            end
        end
    end

    // Monitor for the wide-address instance
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && w_we && w_ready) begin
                w_last_addr = w_addr;
                if (exp_w.size() == 0) begin
                    check(1'b0, "R1", "wide write beyond image", w_addr, 0);
                end else begin
                    logic [23:0] it;
                    it = exp_w.pop_front();
                    check(16'(w_addr) == it[23:8], "R2", "wide destination address", w_addr, it[23:8]);
                    check(w_wdata == it[7:0], "R5", "wide written byte", w_wdata, it[7:0]);
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "ALL", "watchdog expired", 0, 1);
        finish_run();
    end

    task automatic load_a(input logic [31:0] base, input int sess_exp, input bit poke);
        push_image(1'b0, 5, base);
        @(negedge clk); a_start = 1'b1; a_saddr = base;
        @(negedge clk); a_start = 1'b0;
        check(a_cpu == 1'b1, "R7", "cpu_reset after start", a_cpu, 1);
        check(a_cs == 1'b0, "R6", "select after start", a_cs, 0);
        if (poke) begin
            repeat (3000) @(negedge clk);
            a_start = 1'b1; a_saddr = 32'h0000_0040;   // R10: must be ignored
            @(negedge clk); a_start = 1'b0;
        end
        do @(negedge clk); while (!a_done);
        check(exp_a.size() == 0, "R1", "image length", exp_a.size(), 0);
        check(a_cpu == 1'b0, "R7", "cpu_reset released with done", a_cpu, 0);
        check(a_cs == 1'b1, "R6", "deselect at done", a_cs, 1);
        check(a_cmd == 8'h03, "R3", "read command", a_cmd, 8'h03);
        check(a_aseen == (base & 32'h00FF_FFFF), "R3", "24-bit address", a_aseen, base & 32'h00FF_FFFF);
        check(a_sess == sess_exp, "R10", "one read per load", a_sess, sess_exp);
        @(negedge clk);
        check(a_done == 1'b0, "R8", "done lasts one cycle", a_done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(a_cs == 1'b1, "R11", "reset cs_n", a_cs, 1);
        check(a_sck == 1'b0, "R11", "reset sck", a_sck, 0);
        check(a_we == 1'b0, "R11", "reset mem_we", a_we, 0);
        check(a_cpu == 1'b0, "R11", "reset cpu_reset", a_cpu, 0);
        check(a_done == 1'b0, "R11", "reset done", a_done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Plain load, upper address byte must be dropped; a stray start mid-copy
        load_a(32'h7F12_3400, 1, 1'b1);
        // Load with memory back-pressure
        stall_mode = 1'b1;
        load_a(32'h0001_0000, 2, 1'b0);
        stall_mode = 1'b0;

        // Wide-address instance, I/O page at the top of the space
        push_image(1'b1, 7, 32'h8100_0F00);
        @(negedge clk); w_start = 1'b1; w_saddr = 32'h8100_0F00;
        @(negedge clk); w_start = 1'b0;
        do @(negedge clk); while (!w_done);
        check(exp_w.size() == 0, "R1", "wide image length", exp_w.size(), 0);
        check(w_cmd == 8'h13, "R4", "wide read command", w_cmd, 8'h13);
        check(w_aseen == 32'h8100_0F00, "R4", "32-bit address", w_aseen, 32'h8100_0F00);
        check(16'(w_last_addr) == 16'h06FF, "R2", "last address below top I/O page", w_last_addr, 16'h06FF);
        check(w_sess == 1, "R6", "wide select count", w_sess, 1);
        check(w_cpu == 1'b0, "R7", "wide cpu_reset released", w_cpu, 0);
        @(negedge clk);
        check(w_done == 1'b0, "R8", "wide done pulse width", w_done, 0);
        finish_run();
    end
endmodule